// File: doc/BRIEF.md
# LIFO Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words of 8 bits, kept in registers beside a 6-bit stack pointer. A push request advances the pointer by one and then writes the input word into the word the pointer now names. A pop request reads the word the pointer names into a registered output and then moves the pointer back by one. The pointer counts modulo the depth. As a result, after reset the first word lands at index 1, and the 64th word lands at index 0.

The two flags are not derived from an occupancy count. They are set when the pointer wraps to zero. FULL is set when a push brings the pointer to zero, and every accepted push clears EMPTY. EMPTY is set when a pop brings the pointer to zero, and every accepted pop clears FULL. A push while FULL and a pop while EMPTY change nothing and give a one-cycle error pulse. A cycle that requests both push and pop does nothing at all.

The asynchronous active-low reset is released through a two-stage synchronizer. Every output is registered.

Top module: `lifo_stack`

## Requirements
- R1: While reset is held, and after it is released, EMPTY is 1 and FULL is 0. Error is 0, read-valid is 0 and the read data is 0x00.
- R2: Accepted pops return the pushed words in reverse order of their pushes.
- R3: The popped word and a read-valid of 1 appear in the cycle after the pop request. When no pop is accepted, read-valid is 0 and the read data holds its last value.
- R4: An accepted push clears EMPTY. FULL stays 0 through the first 63 pushes from empty and becomes 1 on the 64th, which wraps the pointer to 0.
- R5: An accepted pop clears FULL. The pop that brings the pointer back to 0 sets EMPTY.
- R6: A push while FULL is ignored. Error is 1 for the following cycle, FULL stays 1, and the stored words are unchanged.
- R7: A pop while EMPTY is ignored. Error is 1 for the following cycle, read-valid stays 0, the read data is unchanged, and EMPTY stays 1.
- R8: A cycle with push and pop both requested performs neither. The flags keep their values and error stays 0.
- R9: FULL and EMPTY are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din_i | input | 8 | Word to push |
| dout_o | output | 8 | Last popped word |
| rd_vld_o | output | 1 | dout_o was loaded by the previous cycle's pop |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| err_o | output | 1 | Previous cycle's request was rejected |

## Verification
Each result is produced by a single register stage, so it is due exactly one clock edge after the request. This covers the flags, the error pulse, the popped word and its valid bit. The bench changes the inputs on the falling edge and samples every output on the next falling edge, which is half a period after the edge that loaded it. After reset is released, the bench waits for the synchronizer's two edges plus margin before the first request. Rejected and simultaneous requests are checked in the same cycle slot for unchanged flags and read data. Dropped writes are checked later, by popping the whole stack and comparing every word.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_REJ  = 2'd3
  } op_e;
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  logic full_i,
  input  logic empty_i,
  output op_e  op_o,
  output logic err_o
);
  op_e  op_d;
  logic err_d, err_q;

  // Request decode: a simultaneous push and pop is a no-op
  always_comb begin
    op_d = OP_IDLE;
    if (push_i && !pop_i) op_d = full_i  ? OP_REJ : OP_PUSH;
    if (pop_i && !push_i) op_d = empty_i ? OP_REJ : OP_POP;
  end

  always_comb err_d = (op_d == OP_REJ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign op_o  = op_d;
  assign err_o = err_q;
endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr
  import lifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_inc_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic          full_q, full_d, empty_q, empty_d;
  logic          sp_en;

  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;
  assign sp_en  = (op_i == OP_PUSH) || (op_i == OP_POP);

  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    case (op_i)
      OP_PUSH: begin
        sp_d    = sp_inc;
        empty_d = 1'b0;
        full_d  = (sp_inc == '0);
      end
      OP_POP: begin
        sp_d    = sp_dec;
        full_d  = 1'b0;
        empty_d = (sp_dec == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (sp_en) begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign sp_o     = sp_q;
  assign sp_inc_o = sp_inc;
  assign full_o   = full_q;
  assign empty_o  = empty_q;
endmodule

// File: rtl/lifo_mem.sv
module lifo_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvld_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];
  logic [DW-1:0] rdata_q;
  logic          rvld_q;

  // Storage carries no reset
  always_ff @(posedge clk) begin
    if (we_i) words[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= words[raddr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld_q <= 1'b0;
    else        rvld_q <= re_i;
  end

  assign rdata_o = rdata_q;
  assign rvld_o  = rvld_q;
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 64,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          rd_vld_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam int AW = $clog2(DEPTH);

  logic [SYNC_ST-1:0] rst_pipe;
  logic               rst_s;
  op_e                op;
  logic [AW-1:0]      sp, sp_inc;
  logic               full, empty;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_ST-2:0], 1'b1};
  end
  assign rst_s = rst_pipe[SYNC_ST-1];

  lifo_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_s),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full),
    .empty_i (empty),
    .op_o    (op),
    .err_o   (err_o)
  );

  lifo_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_s),
    .op_i     (op),
    .sp_o     (sp),
    .sp_inc_o (sp_inc),
    .full_o   (full),
    .empty_o  (empty)
  );

  lifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s),
    .we_i    (op == OP_PUSH),
    .waddr_i (sp_inc),
    .wdata_i (din_i),
    .re_i    (op == OP_POP),
    .raddr_i (sp),
    .rdata_o (dout_o),
    .rvld_o  (rd_vld_o)
  );

  assign full_o  = full;
  assign empty_o = empty;
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk (
  input logic clk,
  input logic rst_s,
  input logic push_i,
  input logic pop_i,
  input logic full_o,
  input logic empty_o,
  input logic err_o,
  input logic rd_vld_o
);
  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(full_o && empty_o));

  // R6
  push_full_rej_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (push_i && !pop_i && full_o) |=> (err_o && full_o && !rd_vld_o));

  // R7
  pop_empty_rej_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pop_i && !push_i && empty_o) |=> (err_o && empty_o && !rd_vld_o));

  // R8
  both_noop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (push_i && pop_i) |=> ($stable(full_o) && $stable(empty_o) && !err_o && !rd_vld_o));

  // R4
  push_clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (push_i && !pop_i && !full_o) |=> (!empty_o && !err_o));

  // R3 and R5
  pop_vld_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pop_i && !push_i && !empty_o) |=> (rd_vld_o && !full_o && !err_o));
endmodule

bind lifo_stack lifo_stack_chk u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .push_i   (push_i),
  .pop_i    (pop_i),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .err_o    (err_o),
  .rd_vld_o (rd_vld_o)
);

// File: tb/sim_lifo_stack.sv
`timescale 1ns/1ps
module sim_lifo_stack;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic [7:0] dout_o;
  logic       rd_vld_o, full_o, empty_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lifo_stack u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
    .dout_o(dout_o), .rd_vld_o(rd_vld_o), .full_o(full_o), .empty_o(empty_o),
    .err_o(err_o)
  );

  // {push, pop, din, exp_dout, exp_vld, exp_full, exp_empty, exp_err}
  localparam logic [21:0] VEC [12] = '{
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h22, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h44, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h44, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h66, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h55, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic p, input logic q, input logic [7:0] d);
    push_i = p; pop_i = q; din_i = d;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic chk_all(input string req, input logic [7:0] ed, input logic ev,
                         input logic ef, input logic ee, input logic er);
    chk(req, "dout", dout_o, ed);
    chk(req, "rd_vld", {7'd0, rd_vld_o}, {7'd0, ev});
    chk(req, "full", {7'd0, full_o}, {7'd0, ef});
    chk(req, "empty", {7'd0, empty_o}, {7'd0, ee});
    chk(req, "err", {7'd0, err_o}, {7'd0, er});
  endtask

  task automatic reset_release();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    chk_all("R1", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    reset_release();
    // R1: after release
    chk_all("R1", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);

    // Table: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][21], VEC[i][20], VEC[i][19:12]);
      chk_all("R2/R3/R7/R8 vec", VEC[i][11:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R4: fill from empty
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, 8'(i * 5 + 7));
      chk("R4", "full", {7'd0, full_o}, {7'd0, (i == 63)});
      chk("R4", "empty", {7'd0, empty_o}, 8'd0);
    end
    chk("R9", "both flags", {7'd0, full_o && empty_o}, 8'd0);

    // R6: push while full
    cyc(1'b1, 1'b0, 8'hAA);
    chk("R6", "err", {7'd0, err_o}, 8'd1);
    chk("R6", "full", {7'd0, full_o}, 8'd1);
    @(negedge clk);
    chk("R6", "err one cycle", {7'd0, err_o}, 8'd0);

    // R8 at full
    cyc(1'b1, 1'b1, 8'hBB);
    chk("R8", "full kept", {7'd0, full_o}, 8'd1);
    chk("R8", "err", {7'd0, err_o}, 8'd0);

    // R2 R5: drain, reverse order, untouched by R6 push
    for (int i = 0; i < 64; i++) begin
      cyc(1'b0, 1'b1, 8'h00);
      chk("R2", "dout", dout_o, 8'((63 - i) * 5 + 7));
      chk("R3", "rd_vld", {7'd0, rd_vld_o}, 8'd1);
      chk("R5", "full", {7'd0, full_o}, 8'd0);
      chk("R5", "empty", {7'd0, empty_o}, {7'd0, (i == 63)});
    end
    @(negedge clk);
    chk("R3", "dout held", dout_o, 8'd7);
    chk("R3", "rd_vld idle", {7'd0, rd_vld_o}, 8'd0);

    // R1: reset in mid-use
    cyc(1'b1, 1'b0, 8'h99);
    cyc(1'b1, 1'b0, 8'h98);
    rst_n = 1'b0;
    #1;
    chk_all("R1", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    reset_release();
    cyc(1'b0, 1'b1, 8'h00);
    chk("R7", "err after reset", {7'd0, err_o}, 8'd1);
    chk("R7", "dout", dout_o, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule